// File: doc/BRIEF.md
# Multi-Level Translation Table Walker

This block turns a 64-bit input virtual address into a physical address by walking a tree of 64-bit descriptors held in memory. A walk starts when a request carries the address, the access direction (read or write), the translation base register, a region-size field and a granule select. The block derives the index width, the input size and the first level from these. It then reads one descriptor per level through a single-outstanding request/response memory port.

A walk ends in one of two ways. On success it returns the translated address, the granule offset mask and the granted permissions. On a fault it returns a fault code and the address of the descriptor that caused it. Block descriptors are accepted above the last level. A write is checked against the read-only bit of every table descriptor on the way down and against the read-only bit of the final descriptor. Choosing which base register applies to an address is done outside the block, and so is caching the results.

Top module: `pt_walker`

## Requirements
- R1: The granule select encodes 0 as 4 KiB (log2 12), 1 as 16 KiB (log2 14) and 2 as 64 KiB (log2 16). The per-level index width is log2 minus 3. The input size is 64 minus the 6-bit region-size field. The first level is 4 minus floor((input size - 4) / index width).
- R2: The first table base is bits [47:0] of the base register, with its bits below (input size - index width * (4 - first level)) cleared. Each descriptor is read at base + 8 * index. The index is the input address shifted right by log2 + (3 - level) * index width and masked to the index width. Input address bits at or above the input size have no effect on any result.
- R3: A granule select of 3, or an input size outside 25..48, ends the walk with fault code 1 (translation), fault address 0 and no memory read.
- R4: Exactly one memory read is issued per level visited, and only one is outstanding at a time. A read request holds its address stable until accepted.
- R5: A read response with the error flag set ends the walk with fault code 3 (walk abort). The fault address is the address of that descriptor.
- R6: A descriptor with bit 0 clear, or with bit 1 clear at level 3, ends the walk with fault code 1 and the descriptor address as fault address.
- R7: At levels 0..2 a descriptor with bits 1:0 = 11 is a table. The next level uses the descriptor's bits [47:log2] as the table base. If the access is a write and descriptor bit 62 is set, the walk ends with fault code 2 (permission) and the descriptor address.
- R8: A page descriptor (bits 1:0 = 11 at level 3) or a block descriptor (bits 1:0 = 01 at levels 0..2) ends the walk with fault code 0. The output address is the descriptor's bits [47:0] with the bits below the level shift replaced by the input address bits below that shift. The fault address is 0.
- R9: A write access to a page or block descriptor with bit 7 set ends the walk with fault code 2 and the descriptor address.
- R10: On success the mask equals 2^log2 - 1 and the permission output is {write = not bit 7, read = 1}. On any fault the permission, output address and mask are 0.
- R11: Each accepted request produces exactly one single-cycle result pulse. Request-ready is high only while no walk is in progress. Result fields hold their value until the next result pulse.
- R12: During and right after reset, request-ready is 1, and the result pulse, the memory request and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_va | input | 64 | Input virtual address |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_base | input | 64 | Translation base register |
| req_tsz | input | 6 | Region-size field |
| req_gran | input | 2 | Granule select |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Descriptor value |
| mem_rsp_err | input | 1 | Read failed |
| done_valid | output | 1 | Single-cycle result pulse |
| done_fault | output | 2 | 0 none, 1 translation, 2 permission, 3 walk abort |
| done_pa | output | PA_W | Translated address |
| done_mask | output | PA_W | Granule offset mask |
| done_perm | output | 2 | {write, read} granted |
| done_fault_addr | output | PA_W | Descriptor address of a fault |

## Verification
Several properties are checked on every cycle: the memory request stays stable while it waits, descriptor addresses are 8-byte aligned, an unsupported configuration yields a translation fault on the next cycle, faults report no permission, and a success keeps the input page offset with a granule-sized mask. The scenarios alone can show the rest. That covers the correct first level and index per granule and region size, and the right descriptor being chosen at each level. It also covers fault classification by descriptor kind, the table read-only check on the way down, block outputs above level 3, and insensitivity to input bits above the input size. These results depend on memory contents that a per-cycle property cannot follow.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

    localparam int DESC_W    = 64;
    localparam int VA_W      = 64;
    localparam int BASE_BITS = 48;

    // descriptor bit positions decoded by the walker
    localparam int D_VALID  = 0;
    localparam int D_KIND   = 1;
    localparam int D_LEAFRO = 7;
    localparam int D_TABRO  = 62;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_XLAT  = 2'd1,
        FLT_PERM  = 2'd2,
        FLT_ABORT = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        DK_INVALID = 2'd0,
        DK_TABLE   = 2'd1,
        DK_LEAF    = 2'd2
    } desc_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } walk_state_e;

    typedef struct packed {
        logic       ok;
        logic [1:0] level;
        logic [4:0] glog;
        logic [3:0] stride;
        logic [6:0] in_size;
    } walk_cfg_t;

    function automatic logic [4:0] gran_log2(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd12;
            2'd1:    return 5'd14;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [3:0] gran_stride(input logic [1:0] sel);
        return 4'(gran_log2(sel) - 5'd3);
    endfunction

endpackage

// File: rtl/pt_cfg_decode.sv
module pt_cfg_decode
    import pt_walk_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [VA_W-1:0] ttb,
    input  logic [5:0]      tsz,
    input  logic [1:0]      gran,
    output walk_cfg_t       cfg,
    output logic [PA_W-1:0] base
);
    logic [6:0] in_size;
    logic [6:0] rem;
    logic [3:0] stride;
    logic [2:0] steps;
    logic [6:0] low_bits;

    assign stride  = gran_stride(gran);
    assign in_size = 7'd64 - {1'b0, tsz};
    assign rem     = in_size - 7'd4;

    // number of whole strides in (input size - 4), found by compares
    always_comb begin
        steps = 3'd0;
        for (int k = 1; k <= 4; k++) begin
            if (int'(rem) >= k * int'(stride)) begin
                steps = steps + 3'd1;
            end
        end
    end

    assign low_bits = 7'(int'(in_size) - int'(steps) * int'(stride));

    always_comb begin
        cfg.ok      = (gran != 2'd3) && (in_size >= 7'd25) && (in_size <= 7'd48);
        cfg.level   = 2'(3'd4 - steps);
        cfg.glog    = gran_log2(gran);
        cfg.stride  = stride;
        cfg.in_size = in_size;
    end

    assign base = ttb[PA_W-1:0] & ({PA_W{1'b1}} << low_bits);

    logic unused_ttb;
    assign unused_ttb = ^ttb[VA_W-1:PA_W];

endmodule

// File: rtl/pt_index_gen.sv
module pt_index_gen
    import pt_walk_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic [VA_W-1:0] va,
    input  logic [6:0]      in_size,
    input  logic [4:0]      glog,
    input  logic [3:0]      stride,
    input  logic [1:0]      level,
    input  logic [PA_W-1:0] base,
    output logic [PA_W-1:0] desc_addr,
    output logic [PA_W-1:0] leaf_mask
);
    logic [5:0]      shamt;
    logic [VA_W-1:0] va_eff;
    logic [VA_W-1:0] idx;

    assign shamt  = 6'(int'(glog) + (3 - int'(level)) * int'(stride));
    // bits at or above the input size never reach the index
    assign va_eff = va & ~({VA_W{1'b1}} << in_size);
    assign idx    = (va_eff >> shamt) & ~({VA_W{1'b1}} << stride);

    assign desc_addr = base + PA_W'({idx[VA_W-4:0], 3'b000});
    assign leaf_mask = ~({PA_W{1'b1}} << shamt);

endmodule

// File: rtl/pt_desc_class.sv
module pt_desc_class
    import pt_walk_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    input  logic [1:0]        level,
    input  logic              is_write,
    output desc_kind_e        kind,
    output logic              perm_fault
);
    always_comb begin
        if (!desc[D_VALID]) begin
            kind = DK_INVALID;
        end else if (level == 2'd3) begin
            kind = desc[D_KIND] ? DK_LEAF : DK_INVALID;
        end else begin
            kind = desc[D_KIND] ? DK_TABLE : DK_LEAF;
        end
    end

    always_comb begin
        case (kind)
            DK_TABLE: perm_fault = is_write && desc[D_TABRO];
            DK_LEAF:  perm_fault = is_write && desc[D_LEAFRO];
            default:  perm_fault = 1'b0;
        endcase
    end

    logic unused_desc;
    assign unused_desc = ^desc;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walk_pkg::*;
#(
    parameter int PA_W = 48
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [63:0]     req_va,
    input  logic            req_write,
    input  logic [63:0]     req_base,
    input  logic [5:0]      req_tsz,
    input  logic [1:0]      req_gran,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [PA_W-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [63:0]     mem_rsp_data,
    input  logic            mem_rsp_err,
    output logic            done_valid,
    output logic [1:0]      done_fault,
    output logic [PA_W-1:0] done_pa,
    output logic [PA_W-1:0] done_mask,
    output logic [1:0]      done_perm,
    output logic [PA_W-1:0] done_fault_addr
);
    typedef struct packed {
        fault_e          fault;
        logic [PA_W-1:0] pa;
        logic [PA_W-1:0] mask;
        logic [1:0]      perm;
        logic [PA_W-1:0] faddr;
    } result_t;

    walk_state_e     state;
    walk_cfg_t       cfg_in;
    logic [PA_W-1:0] base_in;

    logic [VA_W-1:0] va_q;
    logic            wr_q;
    logic [4:0]      glog_q;
    logic [3:0]      stride_q;
    logic [6:0]      in_size_q;
    logic [1:0]      level_q;
    logic [PA_W-1:0] base_q;
    logic [PA_W-1:0] addr_q;

    logic [PA_W-1:0] desc_addr;
    logic [PA_W-1:0] leaf_mask;
    logic [PA_W-1:0] gran_mask;
    desc_kind_e      kind;
    logic            perm_fault;

    logic            finish;
    logic            descend;
    result_t         res_n;
    result_t         res_q;

    pt_cfg_decode #(.PA_W(PA_W)) u_cfg (
        .ttb  (req_base),
        .tsz  (req_tsz),
        .gran (req_gran),
        .cfg  (cfg_in),
        .base (base_in)
    );

    pt_index_gen #(.PA_W(PA_W)) u_idx (
        .va        (va_q),
        .in_size   (in_size_q),
        .glog      (glog_q),
        .stride    (stride_q),
        .level     (level_q),
        .base      (base_q),
        .desc_addr (desc_addr),
        .leaf_mask (leaf_mask)
    );

    pt_desc_class u_cls (
        .desc       (mem_rsp_data),
        .level      (level_q),
        .is_write   (wr_q),
        .kind       (kind),
        .perm_fault (perm_fault)
    );

    assign gran_mask     = ~({PA_W{1'b1}} << glog_q);
    assign req_ready     = (state == S_IDLE);
    assign mem_req_valid = (state == S_ISSUE);
    assign mem_req_addr  = desc_addr;

    // outcome of the current cycle
    always_comb begin
        finish  = 1'b0;
        descend = 1'b0;
        res_n   = '0;
        case (state)
            S_IDLE: begin
                if (req_valid && !cfg_in.ok) begin
                    finish      = 1'b1;
                    res_n.fault = FLT_XLAT;
                end
            end
            S_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        finish      = 1'b1;
                        res_n.fault = FLT_ABORT;
                        res_n.faddr = addr_q;
                    end else if (kind == DK_INVALID) begin
                        finish      = 1'b1;
                        res_n.fault = FLT_XLAT;
                        res_n.faddr = addr_q;
                    end else if (perm_fault) begin
                        finish      = 1'b1;
                        res_n.fault = FLT_PERM;
                        res_n.faddr = addr_q;
                    end else if (kind == DK_LEAF) begin
                        finish      = 1'b1;
                        res_n.fault = FLT_NONE;
                        res_n.pa    = (mem_rsp_data[PA_W-1:0] & ~leaf_mask)
                                    | (va_q[PA_W-1:0] & leaf_mask);
                        res_n.mask  = gran_mask;
                        res_n.perm  = {~mem_rsp_data[D_LEAFRO], 1'b1};
                    end else begin
                        descend     = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            va_q       <= '0;
            wr_q       <= 1'b0;
            glog_q     <= '0;
            stride_q   <= '0;
            in_size_q  <= '0;
            level_q    <= '0;
            base_q     <= '0;
            addr_q     <= '0;
            res_q      <= '0;
            done_valid <= 1'b0;
        end else begin
            done_valid <= finish;
            if (finish) begin
                res_q <= res_n;
                state <= S_IDLE;
            end else begin
                case (state)
                    S_IDLE: begin
                        if (req_valid) begin
                            va_q      <= req_va;
                            wr_q      <= req_write;
                            glog_q    <= cfg_in.glog;
                            stride_q  <= cfg_in.stride;
                            in_size_q <= cfg_in.in_size;
                            level_q   <= cfg_in.level;
                            base_q    <= base_in;
                            state     <= S_ISSUE;
                        end
                    end
                    S_ISSUE: begin
                        if (mem_req_ready) begin
                            addr_q <= desc_addr;
                            state  <= S_WAIT;
                        end
                    end
                    S_WAIT: begin
                        if (descend) begin
                            base_q  <= mem_rsp_data[PA_W-1:0] & ~gran_mask;
                            level_q <= level_q + 2'd1;
                            state   <= S_ISSUE;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    assign done_fault      = res_q.fault;
    assign done_pa         = res_q.pa;
    assign done_mask       = res_q.mask;
    assign done_perm       = res_q.perm;
    assign done_fault_addr = res_q.faddr;

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R2
    desc_align_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

    // R3
    bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !cfg_in.ok |=> done_valid && done_fault == 2'd1);

    // R10
    fault_noperm_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault != 2'd0 |-> done_perm == 2'd0 && done_mask == '0);

    // R10
    ok_mask_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault == 2'd0 |->
            done_perm[0] && ($countones(done_mask) == 12 ||
                             $countones(done_mask) == 14 ||
                             $countones(done_mask) == 16));

    // R8
    page_off_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault == 2'd0 |->
            (done_pa & done_mask) == (va_q[PA_W-1:0] & done_mask));

    // R11
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
    localparam int PA_W = 48;
    localparam logic [3:0] K_TAB = 4'd0, K_LEAF = 4'd1, K_ERR = 4'd2,
                           K_INV = 4'd3, K_RAND = 4'd4, K_RES = 4'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [63:0]     req_va = '0;
    logic            req_write = 1'b0;
    logic [63:0]     req_base = '0;
    logic [5:0]      req_tsz = '0;
    logic [1:0]      req_gran = '0;
    logic            mem_req_valid;
    logic            mem_req_ready = 1'b0;
    logic [PA_W-1:0] mem_req_addr;
    logic            mem_rsp_valid = 1'b0;
    logic [63:0]     mem_rsp_data = '0;
    logic            mem_rsp_err = 1'b0;
    logic            done_valid;
    logic [1:0]      done_fault;
    logic [PA_W-1:0] done_pa, done_mask, done_fault_addr;
    logic [1:0]      done_perm;

    pt_walker #(.PA_W(PA_W)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_write(req_write), .req_base(req_base), .req_tsz(req_tsz),
        .req_gran(req_gran),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .done_valid(done_valid), .done_fault(done_fault), .done_pa(done_pa),
        .done_mask(done_mask), .done_perm(done_perm),
        .done_fault_addr(done_fault_addr)
    );

    logic [63:0] mem [longint];
    bit          merr [longint];
    int          hs_count = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    // expected results
    logic [1:0]  e_fault, e_perm;
    logic [47:0] e_pa, e_mask, e_faddr;
    int          e_reads;
    string       e_tag;
    // results of the last walk
    logic [1:0]  g_fault, g_perm;
    logic [47:0] g_pa, g_mask, g_faddr;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic longint key_of(input logic [47:0] a);
        return longint'({16'h0, a});
    endfunction

    function automatic int glog_of(input logic [1:0] g);
        return (g == 2'd0) ? 12 : (g == 2'd1) ? 14 : 16;
    endfunction

    function automatic logic [47:0] daddr(input logic [47:0] base, input logic [63:0] vae,
                                          input int lvl, input int g);
        int s;
        int sh;
        logic [63:0] idx;
        s   = g - 3;
        sh  = g + (3 - lvl) * s;
        idx = (vae >> sh) & ((64'd1 << s) - 64'd1);
        return base + idx[47:0] * 48'd8;
    endfunction

    // memory responder: random accept and latency, one read at a time
    initial begin
        bit          pend = 0;
        int          wcnt = 0;
        logic [47:0] a = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            mem_rsp_err   = 1'b0;
            if (pend) begin
                if (wcnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    if (merr.exists(key_of(a))) begin
                        mem_rsp_err  = 1'b1;
                        mem_rsp_data = 64'h0;
                    end else begin
                        mem_rsp_data = mem.exists(key_of(a)) ? mem[key_of(a)] : 64'h0;
                    end
                    pend = 0;
                end else begin
                    wcnt--;
                end
            end
            mem_req_ready = pend ? 1'b0 : (($urandom % 4) != 0);
            if (!pend && mem_req_ready && mem_req_valid) begin
                pend = 1;
                a    = mem_req_addr;
                wcnt = $urandom % 3;
                hs_count++;
            end
        end
    end

    task automatic ref_walk(input logic [63:0] va, input logic wr, input logic [63:0] ttb,
                            input logic [5:0] tsz, input logic [1:0] gran);
        int g, s, is, lvl, sh;
        logic [47:0] base, a, m;
        logic [63:0] vae, d;
        e_fault = 2'd0; e_perm = 2'd0; e_pa = '0; e_mask = '0; e_faddr = '0;
        e_reads = 0; e_tag = "R8";
        is = 64 - int'(tsz);
        if (gran == 2'd3 || is < 25 || is > 48) begin
            e_fault = 2'd1; e_tag = "R3";
            return;
        end
        g    = glog_of(gran);
        s    = g - 3;
        lvl  = 4 - (is - 4) / s;
        base = ttb[47:0] & ~((48'd1 << (is - s * (4 - lvl))) - 48'd1);
        vae  = va & ((64'd1 << is) - 64'd1);
        while (lvl <= 3) begin
            a = daddr(base, vae, lvl, g);
            e_reads++;
            if (merr.exists(key_of(a))) begin
                e_fault = 2'd3; e_faddr = a; e_tag = "R5";
                return;
            end
            d = mem.exists(key_of(a)) ? mem[key_of(a)] : 64'h0;
            if (!d[0] || (lvl == 3 && !d[1])) begin
                e_fault = 2'd1; e_faddr = a; e_tag = "R6";
                return;
            end
            if (lvl < 3 && d[1]) begin
                if (wr && d[62]) begin
                    e_fault = 2'd2; e_faddr = a; e_tag = "R7";
                    return;
                end
                base = d[47:0] & ~((48'd1 << g) - 48'd1);
                lvl++;
            end else begin
                if (wr && d[7]) begin
                    e_fault = 2'd2; e_faddr = a; e_tag = "R9";
                    return;
                end
                sh     = g + (3 - lvl) * s;
                m      = (48'd1 << sh) - 48'd1;
                e_pa   = (d[47:0] & ~m) | (vae[47:0] & m);
                e_mask = (48'd1 << g) - 48'd1;
                e_perm = {~d[7], 1'b1};
                return;
            end
        end
    endtask

    // lays descriptors along the path of va; kinds holds one code per step
    task automatic build(input logic [63:0] va, input logic [63:0] ttb, input logic [5:0] tsz,
                         input logic [1:0] gran, input logic [15:0] kinds,
                         input bit ro_tab, input bit ro_leaf);
        int g, s, is, lvl, step, r;
        logic [3:0]  kd;
        logic [47:0] base, a, rnd, nb;
        logic [63:0] vae, d;
        mem.delete();
        merr.delete();
        is = 64 - int'(tsz);
        if (gran == 2'd3 || is < 25 || is > 48) return;
        g    = glog_of(gran);
        s    = g - 3;
        lvl  = 4 - (is - 4) / s;
        base = ttb[47:0] & ~((48'd1 << (is - s * (4 - lvl))) - 48'd1);
        vae  = va & ((64'd1 << is) - 64'd1);
        step = 0;
        while (lvl <= 3) begin
            a   = daddr(base, vae, lvl, g);
            kd  = kinds[step*4 +: 4];
            rnd = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            if (kd == K_RAND) begin
                r  = $urandom % 16;
                kd = (lvl < 3 && r < 8) ? K_TAB : (r < 12) ? K_LEAF :
                     (r == 12) ? K_ERR : (r == 13) ? K_INV : K_RES;
            end
            if (kd == K_TAB && lvl == 3) kd = K_LEAF;
            if (kd == K_TAB) begin
                nb     = rnd & ~((48'd1 << g) - 48'd1);
                d      = {16'h0, nb} | 64'h3;
                d[62]  = ro_tab;
                d[7]   = rnd[7];
                mem[key_of(a)] = d;
                base = nb;
                lvl++;
                step++;
            end else begin
                if (kd == K_LEAF) begin
                    d      = {16'h0, rnd};
                    d[1:0] = (lvl == 3) ? 2'b11 : 2'b01;
                    d[7]   = ro_leaf;
                    mem[key_of(a)] = d;
                end else if (kd == K_ERR) begin
                    merr[key_of(a)] = 1'b1;
                end else if (kd == K_RES && lvl == 3) begin
                    d      = {16'h0, rnd};
                    d[1:0] = 2'b01;
                    mem[key_of(a)] = d;
                end else begin
                    d    = {$urandom, $urandom};
                    d[0] = 1'b0;
                    mem[key_of(a)] = d;
                end
                lvl = 4;
            end
        end
    endtask

    task automatic walk(input logic [63:0] va, input logic wr, input logic [63:0] ttb,
                        input logic [5:0] tsz, input logic [1:0] gran, input string note);
        int t;
        int hs0;
        bit busy_bad;
        ref_walk(va, wr, ttb, tsz, gran);
        @(negedge clk);
        req_valid = 1'b1; req_va = va; req_write = wr; req_base = ttb;
        req_tsz = tsz; req_gran = gran;
        hs0 = hs_count;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        busy_bad = 0;
        while (!done_valid && t < 1000) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            t++;
        end
        g_fault = done_fault; g_pa = done_pa; g_mask = done_mask;
        g_perm = done_perm; g_faddr = done_fault_addr;
        chk({"R11 ", note}, "done pulse", {63'h0, done_valid}, 64'h1);
        chk({"R11 ", note}, "ready while busy", {63'h0, busy_bad}, 64'h0);
        chk({e_tag, " ", note}, "fault", {62'h0, done_fault}, {62'h0, e_fault});
        chk({e_tag, " ", note}, "fault addr", {16'h0, done_fault_addr}, {16'h0, e_faddr});
        chk({"R8 ", note}, "pa", {16'h0, done_pa}, {16'h0, e_pa});
        chk({"R10 ", note}, "mask", {16'h0, done_mask}, {16'h0, e_mask});
        chk({"R10 ", note}, "perm", {62'h0, done_perm}, {62'h0, e_perm});
        chk({"R4 ", note}, "reads", 64'(hs_count - hs0), 64'(e_reads));
    endtask

    task automatic dir(input logic [63:0] va, input logic wr, input logic [63:0] ttb,
                       input logic [5:0] tsz, input logic [1:0] gran, input logic [15:0] kinds,
                       input bit ro_tab, input bit ro_leaf, input string note);
        build(va, ttb, tsz, gran, kinds, ro_tab, ro_leaf);
        walk(va, wr, ttb, tsz, gran, note);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] va, ttb;
        logic [1:0]  sv_fault, sv_perm;
        logic [47:0] sv_pa, sv_faddr;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        // R12 reset state
        chk("R12", "ready", {63'h0, req_ready}, 64'h1);
        chk("R12", "done", {63'h0, done_valid}, 64'h0);
        chk("R12", "mem req", {63'h0, mem_req_valid}, 64'h0);
        chk("R12", "fault", {62'h0, done_fault}, 64'h0);
        chk("R12", "pa", {16'h0, done_pa}, 64'h0);
        rst = 1'b0;

        va  = 64'h0000_7A5C_3E91_2468;
        ttb = 64'hFFFF_0012_3456_7000;
        // R1 4 KiB granule, 48-bit input: four levels
        dir(va, 1'b0, ttb, 6'd16, 2'd0, {K_LEAF, K_TAB, K_TAB, K_TAB}, 0, 0, "R1 4K L0");
        // R1 64 KiB granule, 42-bit input: starts at level 2
        dir(va, 1'b0, ttb, 6'd22, 2'd2, {K_INV, K_INV, K_LEAF, K_TAB}, 0, 0, "R1 64K L2");
        // R1 16 KiB granule, 47-bit input: starts at level 1
        dir(va, 1'b1, ttb, 6'd17, 2'd1, {K_INV, K_LEAF, K_TAB, K_TAB}, 0, 0, "R1 16K L1");
        // R8 block at the first level with a 39-bit input
        dir(va, 1'b0, ttb, 6'd25, 2'd0, {K_INV, K_INV, K_INV, K_LEAF}, 0, 0, "R8 block L1");
        // R3 unsupported configurations
        dir(va, 1'b0, ttb, 6'd16, 2'd3, 16'h4444, 0, 0, "R3 gran3");
        dir(va, 1'b0, ttb, 6'd40, 2'd0, 16'h4444, 0, 0, "R3 small");
        dir(va, 1'b0, ttb, 6'd15, 2'd1, 16'h4444, 0, 0, "R3 large");
        // R9 write to read-only page, then read of the same
        dir(va, 1'b1, ttb, 6'd16, 2'd0, {K_LEAF, K_TAB, K_TAB, K_TAB}, 0, 1, "R9 wr ro");
        walk(va, 1'b0, ttb, 6'd16, 2'd0, "R10 rd ro");
        // R7 write through read-only table, then read through it
        dir(va, 1'b1, ttb, 6'd16, 2'd0, {K_LEAF, K_TAB, K_TAB, K_TAB}, 1, 0, "R7 wr rotab");
        walk(va, 1'b0, ttb, 6'd16, 2'd0, "R7 rd rotab");
        // R5 read error at the third step
        dir(va, 1'b0, ttb, 6'd16, 2'd0, {K_INV, K_ERR, K_TAB, K_TAB}, 0, 0, "R5 abort");
        // R6 invalid and reserved descriptors
        dir(va, 1'b0, ttb, 6'd16, 2'd0, {K_INV, K_INV, K_INV, K_INV}, 0, 0, "R6 invalid");
        dir(va, 1'b0, ttb, 6'd16, 2'd0, {K_RES, K_TAB, K_TAB, K_TAB}, 0, 0, "R6 reserved");
        // R2 bits above the input size change nothing
        dir(va, 1'b0, ttb, 6'd20, 2'd0, {K_LEAF, K_TAB, K_TAB, K_TAB}, 0, 0, "R2 base");
        sv_fault = g_fault; sv_pa = g_pa; sv_perm = g_perm; sv_faddr = g_faddr;
        walk(va ^ 64'hFFFF_F000_0000_0000, 1'b0, ttb, 6'd20, 2'd0, "R2 high bits");
        chk("R2", "same fault", {62'h0, g_fault}, {62'h0, sv_fault});
        chk("R2", "same pa", {16'h0, g_pa}, {16'h0, sv_pa});
        chk("R2", "same perm", {62'h0, g_perm}, {62'h0, sv_perm});
        chk("R2", "same faddr", {16'h0, g_faddr}, {16'h0, sv_faddr});
        // R11 results hold after the pulse
        repeat (3) @(negedge clk);
        chk("R11", "pulse gone", {63'h0, done_valid}, 64'h0);
        chk("R11", "pa held", {16'h0, done_pa}, {16'h0, sv_pa});
        chk("R11", "fault held", {62'h0, done_fault}, {62'h0, sv_fault});

        // random walks
        for (int i = 0; i < 300; i++) begin
            logic [1:0] gr;
            logic [5:0] tz;
            gr  = (($urandom % 20) == 0) ? 2'd3 : 2'($urandom % 3);
            tz  = (($urandom % 16) == 0) ? 6'($urandom % 64) : 6'(16 + ($urandom % 24));
            va  = {$urandom, $urandom};
            ttb = {$urandom, $urandom};
            build(va, ttb, tz, gr, 16'h4444, ($urandom % 6) == 0, ($urandom % 4) == 0);
            walk(va, 1'($urandom % 2), ttb, tz, gr, "random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule